// File: doc/BRIEF.md
# Single-Precision Invalid-Operation Guard

This block sits beside a single-precision floating-point datapath and checks each arithmetic request for operand combinations that have no meaningful numeric answer. It looks at the opcode and both 32-bit operands of a request. When such a condition is found and the invalid exception is masked, it supplies the default value the destination must receive instead of the datapath result. When the exception is unmasked, it raises a fault pulse and supplies no override, so the destination and operands stay as they were.

The guard picks the default from the class of the operation. It can return a quieted copy of a signaling NaN, the canonical quiet-NaN indefinite, or the integer indefinite for conversions to a 32-bit integer. A small control/status register holds the mask bit and a sticky invalid flag. A detected condition sets the flag whether or not it is masked, and only a register write clears it. The arithmetic, rounding and every other exception class are handled elsewhere.

Top module: `fp_invalid_guard`

## Requirements
- R1: After reset the status register reads 0x80: mask bit 7 is set and flag bit 0 is clear. The override-valid and fault outputs are low.
- R2: For add (opcode 0), subtract (1), multiply (2) or divide (3) with a signaling-NaN operand, the masked result is that NaN made quiet. A signaling NaN has exponent all ones, fraction bit 22 clear and a nonzero fraction. It is made quiet by setting fraction bit 22 and keeping the sign and the rest of the payload. If both operands are signaling, operand A is the one returned.
- R3: Square root (4) and precision convert (5) look only at operand A. A signaling NaN in A returns A made quiet. A square root of a negative, nonzero, non-NaN operand (negative infinity included) returns 0xFFC00000. A square root of negative zero is not invalid.
- R4: Adding two infinities of opposite sign, or subtracting two infinities of the same sign, returns 0xFFC00000.
- R5: Multiplying an infinity by a zero, in either operand order, returns 0xFFC00000, and so does dividing zero by zero or infinity by infinity.
- R6: Convert to 32-bit integer (6) returns 0x80000000 when operand A is a NaN, an infinity, or a value whose truncated integer part does not fit a signed 32-bit integer. The value -2^31 itself fits.
- R7: When mask bit 7 is clear and a condition is detected, fault_o pulses and ovr_valid_o stays low.
- R8: Flag bit 0 is set by every detected condition, masked or not, and keeps its value until a register write. A write in the same cycle as a detected condition still leaves the flag set.
- R9: Requests with no invalid condition produce neither an override nor a fault and leave the flag unchanged. This covers quiet-NaN operands, denormals, reserved opcode 7 and cycles with req_valid_i low.
- R10: Outputs appear in the cycle after the request and last one cycle. The mask used is the one in the register when the request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Operation code |
| opa_i | input | 32 | Operand A (single precision) |
| opb_i | input | 32 | Operand B (single precision) |
| csr_wr_i | input | 1 | Status register write enable |
| csr_wdata_i | input | 8 | Status register write data (bit 7 mask, bit 0 flag) |
| csr_o | output | 8 | Status register contents |
| ovr_valid_o | output | 1 | Override result valid |
| ovr_data_o | output | 32 | Override result value |
| fault_o | output | 1 | Unmasked invalid-operation pulse |

## Verification
Random requests draw operands from a pool of special encodings: both zeros, both infinities, quiet and signaling NaNs, denormals and the values on each side of the integer conversion limits. These are mixed with plain random words, so every opcode meets operand pairs that separate the NaN priority from the infinity and zero rules. Directed cases cover a signaling NaN in both operands, which shows whether operand A is the one chosen, and negative zero under square root, which tells zero apart from negative values. Conversions of exactly -2^31 and of the next float below it check the limit of the range test. Mask toggles and flag-clearing writes, including one that lands in the same cycle as a detection, separate the fault path from the override path and test how long the flag is kept.

// File: rtl/fpinv_pkg.sv
package fpinv_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int QBIT   = FRAC_W - 1;
    localparam int INT_W  = 32;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    // biased exponent of 2^(INT_W-1): first magnitude that no longer fits
    localparam int INT_LIM_EXP = BIAS + INT_W - 1;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_DIV  = 3'd3,
        OP_SQRT = 3'd4,
        OP_CVTF = 3'd5,
        OP_CVTI = 3'd6,
        OP_RSVD = 3'd7
    } fp_op_e;

    typedef struct packed {
        logic              sign;
        logic              nan;
        logic              snan;
        logic              inf;
        logic              zero;
        logic              frac_zero;
        logic [EXP_W-1:0]  exp;
    } fp_cls_t;

    localparam logic [FP_W-1:0]  QNAN_INDEF = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [INT_W-1:0] INT_INDEF  = {1'b1, {(INT_W-1){1'b0}}};
endpackage

// File: rtl/fpinv_classify.sv
module fpinv_classify
    import fpinv_pkg::*;
#(
    parameter int N_OPS = 2
) (
    input  logic [N_OPS-1:0][FP_W-1:0] opnd_i,
    output fp_cls_t [N_OPS-1:0]        cls_o
);
    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        logic [EXP_W-1:0]  exp_w;
        logic [FRAC_W-1:0] frac_w;
        logic              exp_max;
        assign exp_w   = opnd_i[g][FP_W-2 -: EXP_W];
        assign frac_w  = opnd_i[g][FRAC_W-1:0];
        assign exp_max = &exp_w;

        always_comb begin
            cls_o[g].sign      = opnd_i[g][FP_W-1];
            cls_o[g].exp       = exp_w;
            cls_o[g].frac_zero = (frac_w == '0);
            cls_o[g].nan       = exp_max && (frac_w != '0);
            cls_o[g].snan      = exp_max && !frac_w[QBIT] && (frac_w != '0);
            cls_o[g].inf       = exp_max && (frac_w == '0);
            cls_o[g].zero      = (exp_w == '0) && (frac_w == '0);
        end
    end
endmodule

// File: rtl/fpinv_detect.sv
module fpinv_detect
    import fpinv_pkg::*;
(
    input  fp_op_e          op_i,
    input  logic [FP_W-1:0] opa_i,
    input  logic [FP_W-1:0] opb_i,
    input  fp_cls_t         cls_a_i,
    input  fp_cls_t         cls_b_i,
    output logic            hit_o,
    output logic [FP_W-1:0] dflt_o
);
    function automatic logic [FP_W-1:0] make_quiet(input logic [FP_W-1:0] x);
        return {x[FP_W-1:QBIT+1], 1'b1, x[QBIT-1:0]};
    endfunction

    logic two_src;
    logic one_src;
    logic cvt_range_bad;

    always_comb begin
        two_src = (op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_MUL) || (op_i == OP_DIV);
        one_src = (op_i == OP_SQRT) || (op_i == OP_CVTF);
        // magnitude >= 2^31, except exactly -2^31
        cvt_range_bad = (int'(cls_a_i.exp) > INT_LIM_EXP) ||
                        ((int'(cls_a_i.exp) == INT_LIM_EXP) && !(cls_a_i.sign && cls_a_i.frac_zero));
    end

    always_comb begin
        hit_o  = 1'b0;
        dflt_o = QNAN_INDEF;
        if (two_src && (cls_a_i.snan || cls_b_i.snan)) begin
            hit_o  = 1'b1;
            dflt_o = cls_a_i.snan ? make_quiet(opa_i) : make_quiet(opb_i);
        end else if (one_src && cls_a_i.snan) begin
            hit_o  = 1'b1;
            dflt_o = make_quiet(opa_i);
        end else begin
            unique case (op_i)
                OP_ADD:  hit_o = cls_a_i.inf && cls_b_i.inf && (cls_a_i.sign != cls_b_i.sign);
                OP_SUB:  hit_o = cls_a_i.inf && cls_b_i.inf && (cls_a_i.sign == cls_b_i.sign);
                OP_MUL:  hit_o = (cls_a_i.inf && cls_b_i.zero) || (cls_a_i.zero && cls_b_i.inf);
                OP_DIV:  hit_o = (cls_a_i.zero && cls_b_i.zero) || (cls_a_i.inf && cls_b_i.inf);
                OP_SQRT: hit_o = cls_a_i.sign && !cls_a_i.zero && !cls_a_i.nan;
                OP_CVTI: begin
                    hit_o  = cls_a_i.nan || cls_a_i.inf || cvt_range_bad;
                    dflt_o = FP_W'(INT_INDEF);
                end
                default: hit_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fp_invalid_guard.sv
module fp_invalid_guard
    import fpinv_pkg::*;
#(
    parameter int CSR_W    = 8,
    parameter int FLAG_BIT = 0,
    parameter int MASK_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [2:0]       req_op_i,
    input  logic [FP_W-1:0]  opa_i,
    input  logic [FP_W-1:0]  opb_i,
    input  logic             csr_wr_i,
    input  logic [CSR_W-1:0] csr_wdata_i,
    output logic [CSR_W-1:0] csr_o,
    output logic             ovr_valid_o,
    output logic [FP_W-1:0]  ovr_data_o,
    output logic             fault_o
);
    typedef struct packed {
        logic            flag;
        logic            mask;
        logic            ovr_valid;
        logic [FP_W-1:0] ovr_data;
        logic            fault;
    } guard_st_t;

    localparam guard_st_t RST_ST = '{flag: 1'b0, mask: 1'b1, ovr_valid: 1'b0,
                                     ovr_data: '0, fault: 1'b0};

    fp_cls_t [1:0]        cls_w;
    logic                 hit_w;
    logic [FP_W-1:0]      dflt_w;
    logic                 evt_w;
    guard_st_t            st_d, st_q;

    fpinv_classify #(.N_OPS(2)) u_cls (
        .opnd_i ({opb_i, opa_i}),
        .cls_o  (cls_w)
    );

    fpinv_detect u_det (
        .op_i    (fp_op_e'(req_op_i)),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .cls_a_i (cls_w[0]),
        .cls_b_i (cls_w[1]),
        .hit_o   (hit_w),
        .dflt_o  (dflt_w)
    );

    always_comb begin
        evt_w          = req_valid_i && hit_w;
        st_d           = st_q;
        st_d.flag      = (csr_wr_i ? csr_wdata_i[FLAG_BIT] : st_q.flag) | evt_w;
        st_d.mask      = csr_wr_i ? csr_wdata_i[MASK_BIT] : st_q.mask;
        st_d.ovr_valid = evt_w && st_q.mask;
        st_d.ovr_data  = (evt_w && st_q.mask) ? dflt_w : '0;
        st_d.fault     = evt_w && !st_q.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    always_comb begin
        csr_o           = '0;
        csr_o[FLAG_BIT] = st_q.flag;
        csr_o[MASK_BIT] = st_q.mask;
        ovr_valid_o     = st_q.ovr_valid;
        ovr_data_o      = st_q.ovr_data;
        fault_o         = st_q.fault;
    end
endmodule

// File: rtl/fpinv_checker.sv
module fpinv_checker #(
    parameter int CSR_W    = 8,
    parameter int FLAG_BIT = 0,
    parameter int MASK_BIT = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic             csr_wr_i,
    input logic [CSR_W-1:0] csr_o,
    input logic             ovr_valid_o,
    input logic [31:0]      ovr_data_o,
    input logic             fault_o
);
    AST_FAULT_NOT_WITH_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_o && ovr_valid_o)); // R7

    AST_MASKED_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && csr_o[MASK_BIT]) |=> !fault_o); // R7

    AST_UNMASKED_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !csr_o[MASK_BIT]) |=> !ovr_valid_o); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_o[FLAG_BIT] && !csr_wr_i) |=> csr_o[FLAG_BIT]); // R8

    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_valid_o || fault_o) |-> csr_o[FLAG_BIT]); // R8

    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!ovr_valid_o && !fault_o)); // R9

    AST_NON_NAN_IS_INT_INDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_valid_o && (ovr_data_o[30:23] != 8'hFF)) |-> (ovr_data_o == 32'h8000_0000)); // R6
endmodule

bind fp_invalid_guard fpinv_checker #(
    .CSR_W(CSR_W), .FLAG_BIT(FLAG_BIT), .MASK_BIT(MASK_BIT)
) u_fpinv_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .csr_wr_i    (csr_wr_i),
    .csr_o       (csr_o),
    .ovr_valid_o (ovr_valid_o),
    .ovr_data_o  (ovr_data_o),
    .fault_o     (fault_o)
);

// File: tb/fp_invalid_guard_bench.sv
module fp_invalid_guard_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [2:0]  req_op_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        csr_wr_i = 1'b0;
    logic [7:0]  csr_wdata_i = '0;
    logic [7:0]  csr_o;
    logic        ovr_valid_o;
    logic [31:0] ovr_data_o;
    logic        fault_o;

    int checks = 0;
    int fails  = 0;
    logic m_flag = 1'b0;
    logic m_mask = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_invalid_guard u_fp_invalid_guard (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
        .opa_i(opa_i), .opb_i(opb_i), .csr_wr_i(csr_wr_i), .csr_wdata_i(csr_wdata_i),
        .csr_o(csr_o), .ovr_valid_o(ovr_valid_o), .ovr_data_o(ovr_data_o), .fault_o(fault_o)
    );

    function automatic logic f_snan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22] == 1'b0) && (x[21:0] != 0);
    endfunction
    function automatic logic f_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction
    function automatic logic f_inf(input logic [31:0] x);
        return x[30:0] == 31'h7F80_0000;
    endfunction
    function automatic logic f_zero(input logic [31:0] x);
        return x[30:0] == 0;
    endfunction

    // {hit, default value}
    function automatic logic [32:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [32:0] r;
        r = {1'b0, 32'h0};
        if (op <= 3 && f_snan(a))                  r = {1'b1, a | 32'h0040_0000};
        else if (op <= 3 && f_snan(b))             r = {1'b1, b | 32'h0040_0000};
        else if ((op == 4 || op == 5) && f_snan(a)) r = {1'b1, a | 32'h0040_0000};
        else begin
            case (op)
                3'd0: if (f_inf(a) && f_inf(b) && a[31] != b[31]) r = {1'b1, 32'hFFC0_0000};
                3'd1: if (f_inf(a) && f_inf(b) && a[31] == b[31]) r = {1'b1, 32'hFFC0_0000};
                3'd2: if ((f_inf(a) && f_zero(b)) || (f_zero(a) && f_inf(b))) r = {1'b1, 32'hFFC0_0000};
                3'd3: if ((f_zero(a) && f_zero(b)) || (f_inf(a) && f_inf(b))) r = {1'b1, 32'hFFC0_0000};
                3'd4: if (a[31] && !f_zero(a) && !f_nan(a)) r = {1'b1, 32'hFFC0_0000};
                3'd6: if (a[30:23] > 8'd158 || (a[30:23] == 8'd158 && a != 32'hCF00_0000))
                          r = {1'b1, 32'h8000_0000};
                default: r = {1'b0, 32'h0};
            endcase
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                                     input logic hit, input logic msk);
        if (!hit) return "R9";
        if (!msk) return "R7";
        if (op <= 3 && (f_snan(a) || f_snan(b))) return "R2";
        case (op)
            3'd0, 3'd1: return "R4";
            3'd2, 3'd3: return "R5";
            3'd6:       return "R6";
            default:    return "R3";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic wr, input logic [7:0] wd);
        logic [32:0] e;
        logic [31:0] e_data;
        logic e_ovr, e_flt;
        @(negedge clk);
        req_valid_i = 1'b1; req_op_i = op; opa_i = a; opb_i = b;
        csr_wr_i = wr; csr_wdata_i = wd;
        e      = model(op, a, b);
        e_ovr  = e[32] && m_mask;
        e_flt  = e[32] && !m_mask;
        e_data = e_ovr ? e[31:0] : 32'h0;
        if (wr) begin m_flag = wd[0]; m_mask = wd[7]; end
        m_flag = m_flag | e[32];
        @(negedge clk);
        req_valid_i = 1'b0; csr_wr_i = 1'b0;
        chk(tag_of(op, a, b, e[32], e_flt ? 1'b0 : 1'b1),
            {30'h0, ovr_valid_o, fault_o, ovr_data_o}, {30'h0, e_ovr, e_flt, e_data});
        chk("R8", {56'h0, csr_o}, {56'h0, m_mask, 6'h0, m_flag});
    endtask

    task automatic csr_write(input logic [7:0] wd);
        @(negedge clk);
        csr_wr_i = 1'b1; csr_wdata_i = wd;
        @(negedge clk);
        csr_wr_i = 1'b0;
        m_flag = wd[0]; m_mask = wd[7];
        chk("R8", {56'h0, csr_o}, {56'h0, m_mask, 6'h0, m_flag});
    endtask

    function automatic logic [31:0] pick_opnd();
        logic [31:0] pool [16];
        pool = '{32'h0000_0000, 32'h8000_0000, 32'h7F80_0000, 32'hFF80_0000,
                 32'h7FC0_0001, 32'h7F80_0001, 32'hFFA0_0005, 32'h3F80_0000,
                 32'hC000_0000, 32'h4F00_0000, 32'hCF00_0000, 32'hCF00_0001,
                 32'h4EFF_FFFF, 32'h0000_0001, 32'h7F80_1234, 32'hFFC0_0000};
        if ($urandom_range(0, 2) != 0) return pool[$urandom_range(0, 15)];
        return $urandom;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {54'h0, csr_o, ovr_valid_o, fault_o}, {54'h0, 8'h80, 1'b0, 1'b0});

        do_req(3'd0, 32'h7F80_0000, 32'hFF80_0000, 1'b0, 8'h0);   // R4 +inf + -inf
        do_req(3'd1, 32'hFF80_0000, 32'hFF80_0000, 1'b0, 8'h0);   // R4
        do_req(3'd0, 32'h7F80_0000, 32'h7F80_0000, 1'b0, 8'h0);   // R9 valid sum
        do_req(3'd2, 32'h8000_0000, 32'hFF80_0000, 1'b0, 8'h0);   // R5 zero*inf
        do_req(3'd3, 32'h0000_0000, 32'h8000_0000, 1'b0, 8'h0);   // R5 0/0
        do_req(3'd0, 32'h7F80_0001, 32'hFFA0_0005, 1'b0, 8'h0);   // R2 both SNaN, A wins
        do_req(3'd2, 32'h3F80_0000, 32'hFFA0_0005, 1'b0, 8'h0);   // R2 B quieted
        do_req(3'd4, 32'h8000_0000, 32'h0, 1'b0, 8'h0);           // R3 sqrt -0 ok
        do_req(3'd4, 32'hFF80_0000, 32'h0, 1'b0, 8'h0);           // R3 sqrt -inf
        do_req(3'd5, 32'h3F80_0000, 32'h7F80_0001, 1'b0, 8'h0);   // R3 B ignored
        do_req(3'd6, 32'hCF00_0000, 32'h0, 1'b0, 8'h0);           // R6 -2^31 fits
        do_req(3'd6, 32'hCF00_0001, 32'h0, 1'b0, 8'h0);           // R6 below range
        do_req(3'd6, 32'h4F00_0000, 32'h0, 1'b0, 8'h0);           // R6 2^31
        do_req(3'd7, 32'h7F80_0001, 32'h7F80_0001, 1'b0, 8'h0);   // R9 reserved op
        do_req(3'd0, 32'h7FC0_0001, 32'h3F80_0000, 1'b0, 8'h0);   // R9 QNaN

        // R10: single-cycle pulse, idle afterwards
        @(negedge clk);
        chk("R10", {62'h0, ovr_valid_o, fault_o}, 64'h0);

        csr_write(8'h00);                                           // R8 clear flag, unmask
        do_req(3'd3, 32'h7F80_0000, 32'hFF80_0000, 1'b0, 8'h0);   // R7 fault
        do_req(3'd2, 32'h7F80_0000, 32'h0, 1'b1, 8'h80);          // R8 write+hit, R10 old mask
        do_req(3'd2, 32'h7F80_0000, 32'h0, 1'b0, 8'h0);           // masked now

        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 19) == 0) begin
                logic [7:0] wd;
                wd = {$urandom_range(0, 1) == 0 ? 1'b0 : 1'b1, 6'h0, 1'($urandom_range(0, 1))};
                csr_write(wd);
            end
            do_req(3'($urandom_range(0, 7)), pick_opnd(), pick_opnd(),
                   $urandom_range(0, 30) == 0, 8'($urandom));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule